// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A requester presents the address with its access kind. The walker then reads the directory entry and, for small pages, the table entry. It reports the physical address, whether the page is large, the user and write rights merged over both levels, or a fault. All memory traffic goes through one 32-bit request/ready port. The same port carries the write-backs that set the accessed and dirty flags in the entries.

The table root, the paging switch, the large-page switch and the A20 mask are sampled when a walk starts and held until it ends. Only one walk runs at a time. `busy` is high from the cycle after acceptance until the result cycle. Requests that arrive while `busy` is high are dropped. With paging off, the walk makes no memory access and finishes in a single step.

The controller has six states. WS_IDLE waits for a request. WS_DIR_RD reads the directory entry. WS_DIR_WB writes the directory entry back with its accessed flag set. WS_TBL_RD reads the table entry. WS_LEAF_WB writes back the updated leaf entry. WS_DONE presents the result for one cycle.

The transitions are:
- IDLE to DIR_RD when a request arrives with paging on; IDLE to DONE when paging is off.
- DIR_RD to DONE on a not-present entry, on a reserved-bit fault, or on a large page that needs no update.
- DIR_RD to LEAF_WB on a large page whose flags change.
- DIR_RD to DIR_WB on a small-page pointer whose accessed flag is clear, and DIR_RD to TBL_RD when that flag is already set.
- DIR_WB to TBL_RD.
- TBL_RD to DONE on a not-present entry or when no flag changes; TBL_RD to LEAF_WB otherwise.
- LEAF_WB to DONE, and DONE to IDLE.

Top module: `pgw_top`

## Requirements
- R1: The directory entry address is (table root with bits 11:0 cleared) + 4 × virtual bits 31:22, ANDed with the A20 mask.
- R2: The table entry address is (directory entry with bits 11:0 cleared) + 4 × virtual bits 21:12, ANDed with the A20 mask.
- R3: A clear bit 0 (present) in the directory or table entry ends the walk with `res_absent` high. The address, the rights and `res_big` are then all zero, and that entry is not written.
- R4: A directory entry with bit 7 set, while `big_page_on` is high, yields a 4 MB page. The physical address is {entry bits 20:13, (entry bits 31:22 followed by 22 zeros) AND A20 mask, OR virtual bits 21:0}. With `big_page_on` low, bit 7 is ignored and the entry points to a table.
- R5: A 4 MB directory entry with bit 21 set ends with `res_rsvd` high, zero rights and no write.
- R6: On the small-page path, a directory entry whose bit 5 (accessed) is clear is written back with bit 5 set, before the table read.
- R7: `res_user_ok` is the AND of bit 2 at both levels, and the write right uses the AND of bit 1 at both levels. A 4 MB page uses the directory bits alone.
- R8: The leaf entry gets bit 5 set, and bit 6 (dirty) set as well for kind 1 (write). It is written back only when this changes its value. Kind 0 (read) and kind 2 (fetch) never set bit 6.
- R9: `res_write_ok` is high only when the leaf is dirty after the walk's own update.
- R10: With `paging_on` low, the physical address is (virtual bits 31:12 followed by 12 zeros, AND the A20 mask) OR virtual bits 11:0. Both rights are granted, the page is small, and no memory access is made.
- R11: `busy` is low after reset. It is high from the cycle after a request is accepted until the `done` cycle, and low in the cycle after `done`. A request made while `busy` is high is ignored.
- R12: A memory request keeps its address, write enable and data unchanged until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| req_valid | input | 1 | start a walk (taken when idle) |
| req_vaddr | input | 32 | virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| dir_base | input | 32 | page directory root |
| paging_on | input | 1 | translation enable |
| big_page_on | input | 1 | allow 4 MB directory entries |
| a20_mask | input | 32 | mask applied to entry addresses and frames |
| busy | output | 1 | walk in progress |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | access is a write |
| mem_addr | output | 32 | access address |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, valid with mem_ready |
| mem_ready | input | 1 | access completes this cycle |
| done | output | 1 | result valid (one cycle) |
| res_paddr | output | 40 | physical address |
| res_big | output | 1 | 4 MB page |
| res_user_ok | output | 1 | user access allowed |
| res_write_ok | output | 1 | write allowed now |
| res_absent | output | 1 | not-present fault |
| res_rsvd | output | 1 | reserved-bit fault |

## Verification
Finishing one walk and accepting the next request can fall in the same cycle. The bench raises `req_valid` exactly in the cycle where `done` is high. It then expects `busy` low and no memory request in the next cycle, and no extra result, because the new request met a busy walker. Inside one walk, the directory write-back and the table read are ordered through the same port. The bench compares the full access trace, with addresses and written data, against a trace computed from the requirements.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int unsigned VA_W     = 32;
    localparam int unsigned PTE_W    = 32;
    localparam int unsigned PA_W     = 40;
    localparam int unsigned PG_SHIFT = 12;
    localparam int unsigned BIG_SHIFT = 22;
    localparam int unsigned IX_W     = 10;
    localparam int unsigned ENT_SH   = $clog2(PTE_W / 8);
    localparam int unsigned FR_W     = VA_W - PG_SHIFT;
    localparam int unsigned EXT_W    = PA_W - VA_W;

    // entry flag positions
    localparam int unsigned B_P   = 0;
    localparam int unsigned B_RW  = 1;
    localparam int unsigned B_US  = 2;
    localparam int unsigned B_A   = 5;
    localparam int unsigned B_D   = 6;
    localparam int unsigned B_PS  = 7;
    localparam int unsigned B_RSV = 21;
    localparam int unsigned EXT_LO = 13;
    localparam int unsigned EXT_HI = EXT_LO + EXT_W - 1;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DIR_RD,
        WS_DIR_WB,
        WS_TBL_RD,
        WS_LEAF_WB,
        WS_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    // leaf entry after this access: accessed always, dirty on a write
    function automatic logic [PTE_W-1:0] entry_touch(input logic [PTE_W-1:0] e,
                                                     input logic is_wr);
        logic [PTE_W-1:0] r;
        r = e;
        r[B_A] = 1'b1;
        if (is_wr) r[B_D] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr
    import pgw_pkg::*;
(
    input  logic [FR_W-1:0] base_frame,
    input  logic [IX_W-1:0] dir_idx,
    input  logic [FR_W-1:0] tbl_frame,
    input  logic [IX_W-1:0] tbl_idx,
    input  logic [VA_W-1:0] a20,
    output logic [VA_W-1:0] dir_addr,
    output logic [VA_W-1:0] tbl_addr
);
    localparam int unsigned PAD_W = VA_W - IX_W - ENT_SH;

    logic [VA_W-1:0] dir_sum, tbl_sum;

    always_comb begin
        dir_sum  = {base_frame, {PG_SHIFT{1'b0}}} + {{PAD_W{1'b0}}, dir_idx, {ENT_SH{1'b0}}};
        tbl_sum  = {tbl_frame,  {PG_SHIFT{1'b0}}} + {{PAD_W{1'b0}}, tbl_idx, {ENT_SH{1'b0}}};
        dir_addr = dir_sum & a20;
        tbl_addr = tbl_sum & a20;
    end

    // an entry address is always word aligned
    always_comb begin
        if (dir_addr[ENT_SH-1:0] != '0)
            assert (0) else $error("p_dir_align_r1 misaligned directory entry address");
    end
endmodule

// File: rtl/pgw_result.sv
module pgw_result
    import pgw_pkg::*;
(
    input  logic            off,
    input  logic            big,
    input  logic            bad,
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] a20,
    input  logic            dir_rw,
    input  logic            dir_us,
    input  logic [FR_W-1:0] leaf_frame,
    input  logic            leaf_rw,
    input  logic            leaf_us,
    input  logic            leaf_d,
    output logic [PA_W-1:0] paddr,
    output logic            user_ok,
    output logic            write_ok
);
    localparam int unsigned BIG_FR_W = VA_W - BIG_SHIFT;

    logic [VA_W-1:0]  frame, offset;
    logic [EXT_W-1:0] ext;

    always_comb begin
        ext = '0;
        if (off) begin
            frame    = {vaddr[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
            offset   = {{FR_W{1'b0}}, vaddr[PG_SHIFT-1:0]};
            user_ok  = 1'b1;
            write_ok = 1'b1;
        end else if (big) begin
            frame    = {leaf_frame[FR_W-1:FR_W-BIG_FR_W], {BIG_SHIFT{1'b0}}};
            offset   = {{BIG_FR_W{1'b0}}, vaddr[BIG_SHIFT-1:0]};
            ext      = leaf_frame[EXT_HI-PG_SHIFT:EXT_LO-PG_SHIFT];
            user_ok  = leaf_us;
            write_ok = leaf_rw & leaf_d;
        end else begin
            frame    = {leaf_frame, {PG_SHIFT{1'b0}}};
            offset   = {{FR_W{1'b0}}, vaddr[PG_SHIFT-1:0]};
            user_ok  = dir_us & leaf_us;
            write_ok = dir_rw & leaf_rw & leaf_d;
        end
        paddr = {ext, (frame & a20) | offset};
        if (bad) begin
            paddr    = '0;
            user_ok  = 1'b0;
            write_ok = 1'b0;
        end
    end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [31:0]     req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic [31:0]     dir_base,
    input  logic            paging_on,
    input  logic            big_page_on,
    input  logic [31:0]     a20_mask,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ready,
    output logic            done,
    output logic [39:0]     res_paddr,
    output logic            res_big,
    output logic            res_user_ok,
    output logic            res_write_ok,
    output logic            res_absent,
    output logic            res_rsvd
);
    walk_state_e st_q, st_d;

    logic [VA_W-1:0]  va_q, base_q, a20_q;
    logic [PTE_W-1:0] dir_q, leaf_q, touched;
    logic             wr_q, off_q, pse_q, big_q, absent_q, rsvd_q;
    logic             hs, rd_big;
    logic [VA_W-1:0]  dir_addr, tbl_addr;

    assign hs      = mem_req & mem_ready;
    assign touched = entry_touch(mem_rdata, wr_q);
    assign rd_big  = mem_rdata[B_PS] & pse_q;

    pgw_addr u_addr (
        .base_frame (base_q[VA_W-1:PG_SHIFT]),
        .dir_idx    (va_q[VA_W-1:BIG_SHIFT]),
        .tbl_frame  (dir_q[PTE_W-1:PG_SHIFT]),
        .tbl_idx    (va_q[BIG_SHIFT-1:PG_SHIFT]),
        .a20        (a20_q),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_IDLE: begin
                if (req_valid) st_d = paging_on ? WS_DIR_RD : WS_DONE;
            end
            WS_DIR_RD: begin
                if (hs) begin
                    if (!mem_rdata[B_P])             st_d = WS_DONE;
                    else if (rd_big) begin
                        if (mem_rdata[B_RSV])        st_d = WS_DONE;
                        else if (touched != mem_rdata) st_d = WS_LEAF_WB;
                        else                         st_d = WS_DONE;
                    end
                    else if (!mem_rdata[B_A])        st_d = WS_DIR_WB;
                    else                             st_d = WS_TBL_RD;
                end
            end
            WS_DIR_WB: begin
                if (hs) st_d = WS_TBL_RD;
            end
            WS_TBL_RD: begin
                if (hs) begin
                    if (!mem_rdata[B_P])             st_d = WS_DONE;
                    else if (touched != mem_rdata)   st_d = WS_LEAF_WB;
                    else                             st_d = WS_DONE;
                end
            end
            WS_LEAF_WB: begin
                if (hs) st_d = WS_DONE;
            end
            WS_DONE: st_d = WS_IDLE;
            default: st_d = WS_IDLE;
        endcase
    end

    // walk context and captured entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            base_q   <= '0;
            a20_q    <= '0;
            dir_q    <= '0;
            leaf_q   <= '0;
            wr_q     <= 1'b0;
            off_q    <= 1'b0;
            pse_q    <= 1'b0;
            big_q    <= 1'b0;
            absent_q <= 1'b0;
            rsvd_q   <= 1'b0;
        end else begin
            if (st_q == WS_IDLE && req_valid) begin
                va_q     <= req_vaddr;
                base_q   <= dir_base;
                a20_q    <= a20_mask;
                wr_q     <= (req_kind == ACC_WRITE);
                off_q    <= !paging_on;
                pse_q    <= big_page_on;
                big_q    <= 1'b0;
                absent_q <= 1'b0;
                rsvd_q   <= 1'b0;
            end
            if (st_q == WS_DIR_RD && hs) begin
                dir_q    <= mem_rdata;
                absent_q <= !mem_rdata[B_P];
                if (mem_rdata[B_P] && rd_big) begin
                    big_q  <= 1'b1;
                    rsvd_q <= mem_rdata[B_RSV];
                    leaf_q <= touched;
                end
            end
            if (st_q == WS_TBL_RD && hs) begin
                absent_q <= !mem_rdata[B_P];
                leaf_q   <= touched;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (st_q != WS_IDLE);
        done      = (st_q == WS_DONE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            WS_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            WS_DIR_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dir_q | (PTE_W'(1) << B_A);
            end
            WS_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            WS_LEAF_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = big_q ? dir_addr : tbl_addr;
                mem_wdata = leaf_q;
            end
            default: ;
        endcase
    end

    pgw_result u_res (
        .off        (off_q),
        .big        (big_q),
        .bad        (absent_q | rsvd_q),
        .vaddr      (va_q),
        .a20        (a20_q),
        .dir_rw     (dir_q[B_RW]),
        .dir_us     (dir_q[B_US]),
        .leaf_frame (leaf_q[PTE_W-1:PG_SHIFT]),
        .leaf_rw    (leaf_q[B_RW]),
        .leaf_us    (leaf_q[B_US]),
        .leaf_d     (leaf_q[B_D]),
        .paddr      (res_paddr),
        .user_ok    (res_user_ok),
        .write_ok   (res_write_ok)
    );

    assign res_big    = big_q & !(absent_q | rsvd_q);
    assign res_absent = absent_q;
    assign res_rsvd   = rsvd_q;

    // checks
    p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    p_wb_accessed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[B_A]);
    p_fault_norights_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (res_absent || res_rsvd)) |-> (!res_user_ok && !res_write_ok && !res_big));
    p_req_in_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

// File: tb/sim_pgw_top.sv
module sim_pgw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] cfg_base = '0;
    logic        cfg_pg = 1'b1;
    logic        cfg_pse = 1'b0;
    logic [31:0] cfg_a20 = 32'hFFFF_FFFF;
    logic        busy, mem_req, mem_we, done;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [39:0] res_paddr;
    logic        res_big, res_user_ok, res_write_ok, res_absent, res_rsvd;

    always #5 clk = ~clk;

    pgw_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .dir_base(cfg_base), .paging_on(cfg_pg),
        .big_page_on(cfg_pse), .a20_mask(cfg_a20), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
        .res_paddr(res_paddr), .res_big(res_big), .res_user_ok(res_user_ok),
        .res_write_ok(res_write_ok), .res_absent(res_absent), .res_rsvd(res_rsvd)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } acc_t;

    typedef struct packed {
        logic [39:0] paddr;
        logic        big, uok, wok, absent, rsvd;
    } res_t;

    logic [31:0] mem [logic [31:0]];
    acc_t  exp_tr[$];
    acc_t  got_tr[$];
    res_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input string what, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory responder: ready after 0..3 wait cycles, driven at negedge
    initial begin
        logic [7:0]  lf;
        int          w;
        bit          pend;
        logic [31:0] a0;
        acc_t        cur;
        lf = 8'h5B; w = 0; pend = 0; a0 = '0; cur = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                got_tr.push_back(cur);
                if (cur.we) mem[cur.addr] = cur.data;
                mem_ready = 1'b0;
                pend = 0;
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                w = int'(lf[1:0]);
            end else if (mem_req) begin
                if (!pend) begin pend = 1; a0 = mem_addr; end
                if (w == 0) begin
                    chk("R12", "address held while waiting", mem_addr == a0, 64'(mem_addr), 64'(a0));
                    cur = '{we: mem_we, addr: mem_addr, data: (mem_we ? mem_wdata : 32'h0)};
                    mem_rdata = rd(mem_addr);
                    mem_ready = 1'b1;
                end else w--;
            end
        end
    end

    // monitor: compare each result against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done && rst_n) begin
                if (exp_q.size() == 0) begin
                    chk("R11", "unexpected result", 1'b0, 64'(1), 64'(0));
                end else begin
                    res_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, "paddr", res_paddr == e.paddr, 64'(res_paddr), 64'(e.paddr));
                    chk(t, "flags big/uok/wok/absent/rsvd",
                        {res_big, res_user_ok, res_write_ok, res_absent, res_rsvd} ==
                        {e.big, e.uok, e.wok, e.absent, e.rsvd},
                        64'({res_big, res_user_ok, res_write_ok, res_absent, res_rsvd}),
                        64'({e.big, e.uok, e.wok, e.absent, e.rsvd}));
                end
            end
        end
    end

    // expected result and access trace from the requirements
    task automatic model(input logic [31:0] va, input logic [1:0] kind, input string tag);
        res_t        e;
        logic [31:0] da, ta, pde, pte, nw;
        logic        wr;
        wr = (kind == 2'd1);
        e = '0;
        if (!cfg_pg) begin
            e.paddr = {8'h0, ({va[31:12], 12'h0} & cfg_a20) | {20'h0, va[11:0]}};
            e.uok = 1'b1; e.wok = 1'b1;
        end else begin
            da  = ({cfg_base[31:12], 12'h0} + {20'h0, va[31:22], 2'b00}) & cfg_a20;
            pde = rd(da);
            exp_tr.push_back('{we: 1'b0, addr: da, data: 32'h0});
            if (!pde[0]) e.absent = 1'b1;
            else if (pde[7] && cfg_pse) begin
                if (pde[21]) e.rsvd = 1'b1;
                else begin
                    nw = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
                    if (nw != pde) exp_tr.push_back('{we: 1'b1, addr: da, data: nw});
                    e.big   = 1'b1;
                    e.paddr = {pde[20:13], ({pde[31:22], 22'h0} & cfg_a20) | {10'h0, va[21:0]}};
                    e.uok   = pde[2];
                    e.wok   = pde[1] & nw[6];
                end
            end else begin
                if (!pde[5]) exp_tr.push_back('{we: 1'b1, addr: da, data: pde | 32'h20});
                ta  = ({pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00}) & cfg_a20;
                pte = rd(ta);
                exp_tr.push_back('{we: 1'b0, addr: ta, data: 32'h0});
                if (!pte[0]) e.absent = 1'b1;
                else begin
                    nw = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                    if (nw != pte) exp_tr.push_back('{we: 1'b1, addr: ta, data: nw});
                    e.paddr = {8'h0, ({pte[31:12], 12'h0} & cfg_a20) | {20'h0, va[11:0]}};
                    e.uok   = pde[2] & pte[2];
                    e.wok   = pde[1] & pte[1] & nw[6];
                end
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // driver: one walk, optional request poked into the result cycle
    task automatic walk(input logic [31:0] va, input logic [1:0] kind,
                        input string tag, input bit poke);
        int n;
        model(va, kind, tag);
        got_tr.delete();
        @(negedge clk);
        req_vaddr = va; req_kind = kind; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "busy after accept", busy == 1'b1, 64'(busy), 64'(1));
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        if (n >= 200) chk("R11", "walk timeout", 1'b0, 64'(n), 64'(0));
        if (poke) begin
            req_vaddr = 32'h0040_3000; req_kind = 2'd1; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R11", "request in done cycle ignored: busy", busy == 1'b0, 64'(busy), 64'(0));
            chk("R11", "request in done cycle ignored: mem_req", mem_req == 1'b0, 64'(mem_req), 64'(0));
            repeat (3) @(negedge clk);
        end else begin
            @(negedge clk);
            chk("R11", "idle after done", busy == 1'b0, 64'(busy), 64'(0));
        end
        chk(tag, "trace length", got_tr.size() == exp_tr.size(),
            64'(got_tr.size()), 64'(exp_tr.size()));
        if (got_tr.size() == exp_tr.size()) begin
            foreach (exp_tr[i])
                chk(tag, "trace entry", got_tr[i] == exp_tr[i], 64'(got_tr[i]), 64'(exp_tr[i]));
        end
        exp_tr.delete();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk("R11", "watchdog expired", 1'b0, 64'(0), 64'(1));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // tables: root 0x10000, small-page table at 0x20000 and 0x30000
        mem[32'h0001_0004] = 32'h0002_0007;          // dir 1: P RW US, A clear
        mem[32'h0002_000C] = 32'h0055_5027;          // P RW US A
        mem[32'h0002_0010] = 32'h0066_6061;          // P A D, not RW, not US
        mem[32'h0002_0018] = 32'h0088_8005;          // P US, A clear
        mem[32'h0001_0008] = 32'h0003_0023;          // dir 2: P RW A, not US
        mem[32'h0003_0014] = 32'h0077_7067;          // P RW US A D
        mem[32'h0001_0020] = 32'h0C0B_4087;          // dir 8: 4 MB, ext 0x5A
        mem[32'h0001_0024] = 32'h0120_0087;          // dir 9: 4 MB, bit 21 set
        mem[32'h0000_0000] = 32'h0012_0027;          // for A20 case
        mem[32'h0002_0004] = 32'h0011_1067;

        repeat (3) @(negedge clk);
        chk("R11", "reset busy", busy == 1'b0, 64'(busy), 64'(0));
        chk("R11", "reset mem_req", mem_req == 1'b0, 64'(mem_req), 64'(0));
        chk("R11", "reset done", done == 1'b0, 64'(done), 64'(0));
        rst_n = 1'b1;
        cfg_base = 32'h0001_0000;

        walk(32'h0040_3123, 2'd0, "R6 R1 R2 R9 read", 0);   // dir write-back, no leaf write
        walk(32'h0040_3123, 2'd1, "R8 write sets dirty", 0);
        walk(32'h0040_3123, 2'd0, "R8 no change no write", 0);
        walk(32'h0040_4456, 2'd0, "R7 table denies", 0);
        walk(32'h0080_5abc, 2'd1, "R7 directory denies user", 0);
        walk(32'h0040_6000, 2'd2, "R8 fetch no dirty", 0);
        walk(32'h00C0_0000, 2'd0, "R3 directory absent", 0);
        walk(32'h0040_5000, 2'd1, "R3 table absent", 0);
        cfg_pse = 1'b1;
        walk(32'h0212_3456, 2'd0, "R4 big page read", 0);
        walk(32'h0212_3456, 2'd1, "R4 R9 big page write", 0);
        walk(32'h0212_3456, 2'd0, "R8 big no change", 1);   // R11 same-cycle poke
        walk(32'h0245_6789, 2'd1, "R5 reserved bit", 0);
        cfg_pse = 1'b0;
        walk(32'h0212_3456, 2'd0, "R4 size bit ignored", 0);
        cfg_base = 32'h0010_0000;
        cfg_a20  = 32'hFFEF_FFFF;
        walk(32'h0000_1ABC, 2'd0, "R1 R2 a20 masking", 0);
        cfg_pg = 1'b0;
        walk(32'h1234_5678, 2'd1, "R10 paging off", 0);

        repeat (5) @(negedge clk);
        chk("R11", "no leftover results", exp_q.size() == 0, 64'(exp_q.size()), 64'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule